// File: doc/BRIEF.md
# Codec Output Release Sequencer

This block decides, for each converter path of a stereo audio codec, whether the output word may carry live samples. It watches a power-on reset, an active-low power-down pin for the analog-to-digital (ADC) path, an active-low power-down pin for the digital-to-analog (DAC) path, a one-cycle sample strobe at the frame rate, and a flag that reports that the frame clock has slipped against the system clock. From these it produces the ADC output word, forced to zero while muted, and the DAC output word, forced to ground or to mid-scale while muted.

Each path runs its own sequencer. After a reset or power-down ends, the path first stays in reset for a fixed number of system clock cycles. It then stays muted for a long, path-specific number of sample periods. A slip of the frame clock mutes both paths on the next sample boundary. Once the slip clears, each path stays muted for a short number of sample periods before it resumes. Any new event during a hold restarts the count. Every hold length is a parameter, so a bench can shorten it.

Top module: `codec_mute_seq`

## Requirements
- R1: While `rst_n` is low, `adc_dout` is 0, `dac_dout` is 16'h0000 (ground), `adc_live` is 0 and `dac_lvl` is 0 (ground). Release from this reset follows the same sequence as release from power-down.
- R2: If `adc_pd_n` is low at a clock edge, the ADC word is zero from that edge on. If `dac_pd_n` is low at a clock edge, the DAC shows ground (`dac_lvl`=0, word 16'h0000) from that edge on. Each pin leaves the other path's outputs unchanged.
- R3: After the reset or power-down input goes inactive, a path stays in reset for the first RST_CLKS clock edges. The hold starts at the first edge after those on which `fs_tick` is high. From that edge the DAC shows mid-scale (`dac_lvl`=1, word 16'h8000).
- R4: The ADC word stays zero for ADC_HOLD_FS `fs_tick` edges counted after the hold starts. From the last of them, `adc_dout` equals `adc_din` and `adc_live` is 1.
- R5: The DAC stays at mid-scale for DAC_HOLD_FS `fs_tick` edges counted after the hold starts. From the last of them, `dac_lvl` is 2 and `dac_dout` is `dac_din` (two's complement) with its MSB inverted (offset binary).
- R6: If `sync_lost` is high on an `fs_tick` edge while a path is live, that path mutes at that edge: the ADC word becomes zero and the DAC goes to mid-scale.
- R7: After `sync_lost` returns low, a muted path resumes on the SYNC_HOLD_FS-th following `fs_tick` edge. `sync_lost` high on any edge during this wait restarts the count.
- R8: A power-down during any hold sends the path back to reset. The full sequence then starts again.
- R9: A path moves from reset to hold, and from muted to live, only on a clock edge where `fs_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| adc_pd_n | input | 1 | ADC path power-down, active low |
| dac_pd_n | input | 1 | DAC path power-down, active low |
| fs_tick | input | 1 | One-cycle strobe once per sample period |
| sync_lost | input | 1 | Frame clock has slipped against the system clock |
| adc_din | input | DATA_W | Sample word from the ADC filter |
| dac_din | input | DATA_W | Two's complement sample word for the DAC |
| adc_dout | output | DATA_W | ADC word, zero while muted |
| dac_dout | output | DATA_W | Offset-binary DAC word: 0 ground, 8000h mid-scale |
| adc_live | output | 1 | ADC path passes live data |
| dac_lvl | output | 2 | DAC level: 0 ground, 1 mid-scale, 2 live |

## Verification
The hardest situations to reach are the restarts. One is a sync flag that pulses between two sample strobes in the middle of a resync wait. The other is a one-cycle power-down pulse that lands in the middle of a long DAC hold. A restart bug shows only as a release that comes a few samples too early. The bench therefore generates `fs_tick` itself at a fixed divide. This lets it place each pulse exactly one clock after a strobe edge. It then counts the strobe edges up to the one before the expected release and the release itself.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  typedef enum logic [2:0] {
    PS_RST    = 3'd0,
    PS_PD     = 3'd1,
    PS_SETTLE = 3'd2,
    PS_LIVE   = 3'd3,
    PS_RESYNC = 3'd4
  } path_st_t;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_DATA = 2'd2
  } dac_lvl_t;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/codec_path_seq.sv
module codec_path_seq
  import codec_seq_pkg::*;
#(
  parameter int HOLD_FS  = 18432,
  parameter int SYNC_FS  = 32,
  parameter int RST_CLKS = 1024
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pd_n,
  input  logic     fs_tick,
  input  logic     sync_lost,
  output path_st_t st_o
);

  localparam int CNT_W = cnt_bits(max_of(HOLD_FS, SYNC_FS));
  localparam int RCW   = cnt_bits(RST_CLKS);
  localparam logic [RCW-1:0]   RST_TOP   = RCW'(RST_CLKS);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_FS - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_FS - 1);

  path_st_t         st;
  logic [RCW-1:0]   clk_cnt;
  logic [CNT_W-1:0] fs_cnt;

  // named events for the checks below
  logic rst_window_done;
  logic hold_done;
  logic resync_done;
  assign rst_window_done = (clk_cnt == RST_TOP);
  assign hold_done       = fs_tick && !sync_lost && (fs_cnt == HOLD_LAST);
  assign resync_done     = fs_tick && !sync_lost && (fs_cnt == SYNC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PS_RST;
      clk_cnt <= '0;
      fs_cnt  <= '0;
    end else if (!pd_n) begin
      st      <= PS_PD;
      clk_cnt <= '0;
      fs_cnt  <= '0;
    end else begin
      case (st)
        PS_PD: begin
          st      <= PS_RST;
          clk_cnt <= RCW'(1);
        end
        PS_RST: begin
          if (!rst_window_done) begin
            clk_cnt <= clk_cnt + RCW'(1);
          end else if (fs_tick) begin
            st     <= PS_SETTLE;
            fs_cnt <= '0;
          end
        end
        PS_SETTLE: begin
          if (sync_lost) fs_cnt <= '0;
          else if (hold_done) st <= PS_LIVE;
          else if (fs_tick) fs_cnt <= fs_cnt + CNT_W'(1);
        end
        PS_LIVE: begin
          if (fs_tick && sync_lost) begin
            st     <= PS_RESYNC;
            fs_cnt <= '0;
          end
        end
        PS_RESYNC: begin
          if (sync_lost) fs_cnt <= '0;
          else if (resync_done) st <= PS_LIVE;
          else if (fs_tick) fs_cnt <= fs_cnt + CNT_W'(1);
        end
        default: st <= PS_RST;
      endcase
    end
  end

  assign st_o = st;

  AST_PD_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (st == PS_PD)); // R2

  AST_HOLD_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_SETTLE && $past(st) == PS_RST) |-> ($past(fs_tick) && $past(clk_cnt) == RST_TOP)); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fs_cnt <= CNT_W'(max_of(HOLD_FS, SYNC_FS) - 1)); // R4

  AST_SYNC_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_LIVE && fs_tick && sync_lost && pd_n) |=> (st == PS_RESYNC)); // R6

  AST_LIVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_LIVE && $past(st) != PS_LIVE) |-> $past(fs_tick)); // R9

endmodule

// File: rtl/codec_word_map.sv
module codec_word_map
  import codec_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  path_st_t     adc_st,
  input  path_st_t     dac_st,
  input  logic [W-1:0] adc_din,
  input  logic [W-1:0] dac_din,
  output logic [W-1:0] adc_dout,
  output logic [W-1:0] dac_dout,
  output logic         adc_live,
  output dac_lvl_t     dac_lvl
);

  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] adc_word(path_st_t s, logic [W-1:0] d);
    return (s == PS_LIVE) ? d : '0;
  endfunction

  function automatic dac_lvl_t dac_level(path_st_t s);
    case (s)
      PS_LIVE:             return LVL_DATA;
      PS_SETTLE, PS_RESYNC: return LVL_MID;
      default:             return LVL_GND;
    endcase
  endfunction

  // two's complement in, offset binary out
  function automatic logic [W-1:0] dac_word(dac_lvl_t l, logic [W-1:0] d);
    case (l)
      LVL_DATA: return d ^ MSB_ONLY;
      LVL_MID:  return MSB_ONLY;
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    adc_live = (adc_st == PS_LIVE);
    adc_dout = adc_word(adc_st, adc_din);
    dac_lvl  = dac_level(dac_st);
    dac_dout = dac_word(dac_lvl, dac_din);
  end

endmodule

// File: rtl/codec_mute_seq.sv
module codec_mute_seq
  import codec_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int RST_CLKS     = 1024,
  parameter int ADC_HOLD_FS  = 18432,
  parameter int DAC_HOLD_FS  = 16384,
  parameter int SYNC_HOLD_FS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_pd_n,
  input  logic              dac_pd_n,
  input  logic              fs_tick,
  input  logic              sync_lost,
  input  logic [DATA_W-1:0] adc_din,
  input  logic [DATA_W-1:0] dac_din,
  output logic [DATA_W-1:0] adc_dout,
  output logic [DATA_W-1:0] dac_dout,
  output logic              adc_live,
  output logic [1:0]        dac_lvl
);

  localparam int NPATH = 2;  // index 0: ADC, 1: DAC

  logic [NPATH-1:0] pd_vec;
  path_st_t         st_arr [NPATH];
  dac_lvl_t         lvl_e;

  assign pd_vec = {dac_pd_n, adc_pd_n};

  for (genvar k = 0; k < NPATH; k++) begin : g_path
    localparam int HOLD = (k == 0) ? ADC_HOLD_FS : DAC_HOLD_FS;
    codec_path_seq #(
      .HOLD_FS (HOLD),
      .SYNC_FS (SYNC_HOLD_FS),
      .RST_CLKS(RST_CLKS)
    ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_n     (pd_vec[k]),
      .fs_tick  (fs_tick),
      .sync_lost(sync_lost),
      .st_o     (st_arr[k])
    );
  end

  codec_word_map #(.W(DATA_W)) u_map (
    .adc_st  (st_arr[0]),
    .dac_st  (st_arr[1]),
    .adc_din (adc_din),
    .dac_din (dac_din),
    .adc_dout(adc_dout),
    .dac_dout(dac_dout),
    .adc_live(adc_live),
    .dac_lvl (lvl_e)
  );

  assign dac_lvl = lvl_e;

  AST_DAC_GND_ON_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_pd_n |=> (dac_lvl == 2'd0 && dac_dout == '0)); // R2

  AST_ADC_ZERO_ON_PD: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_pd_n |=> (!adc_live && adc_dout == '0)); // R2

endmodule

// File: tb/codec_mute_seq_tb.sv
`timescale 1ns/1ps
module codec_mute_seq_tb_top;

  localparam int RST_CLKS = 8;
  localparam int ADC_HOLD = 6;
  localparam int DAC_HOLD = 4;
  localparam int SYNC_HOLD = 3;
  localparam int FS_DIV = 10;

  localparam logic [15:0] ADC_D  = 16'h1234;
  localparam logic [15:0] DAC_D  = 16'h8001;
  localparam logic [15:0] DAC_LW = 16'h0001;
  localparam logic [15:0] MID_W  = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic adc_pd_n = 1'b1, dac_pd_n = 1'b1, fs_tick = 1'b0, sync_lost = 1'b0;
  logic [15:0] adc_din = ADC_D, dac_din = DAC_D;
  logic [15:0] adc_dout, dac_dout;
  logic adc_live;
  logic [1:0] dac_lvl;

  always #4 clk = ~clk;

  codec_mute_seq #(
    .DATA_W(16), .RST_CLKS(RST_CLKS), .ADC_HOLD_FS(ADC_HOLD),
    .DAC_HOLD_FS(DAC_HOLD), .SYNC_HOLD_FS(SYNC_HOLD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .adc_pd_n(adc_pd_n), .dac_pd_n(dac_pd_n),
    .fs_tick(fs_tick), .sync_lost(sync_lost), .adc_din(adc_din), .dac_din(dac_din),
    .adc_dout(adc_dout), .dac_dout(dac_dout), .adc_live(adc_live), .dac_lvl(dac_lvl)
  );

  typedef struct {
    string       tag;
    logic [15:0] a;
    logic [15:0] d;
    logic        al;
    logic [1:0]  lv;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // monitor: pop one expected item per falling edge and compare
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      compared++;
      if (adc_dout !== cur.a || dac_dout !== cur.d || adc_live !== cur.al || dac_lvl !== cur.lv) begin
        mismatched++;
        $display("FAIL %s: adc_dout=%h/%h dac_dout=%h/%h adc_live=%b/%b dac_lvl=%0d/%0d (actual/expected)",
                 cur.tag, adc_dout, cur.a, dac_dout, cur.d, adc_live, cur.al, dac_lvl, cur.lv);
      end
    end
  end

  // driver side: push the expected outputs for a path state pair
  task automatic expect_st(string tag, logic a_live, logic [1:0] lvl);
    exp_t e;
    e.tag = tag;
    e.al  = a_live;
    e.a   = a_live ? ADC_D : 16'h0000;
    e.lv  = lvl;
    e.d   = (lvl == 2'd2) ? DAC_LW : (lvl == 2'd1) ? MID_W : 16'h0000;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wait_tick();
    @(posedge clk iff fs_tick);
    #1;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      repeat (FS_DIV - 1) @(posedge clk);
      #1 fs_tick = 1'b1;
      @(posedge clk);
      #1 fs_tick = 1'b0;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    edges(2);
    expect_st("R1 reset state", 1'b0, 2'd0);
    rst_n = 1'b1;
    edges(RST_CLKS);
    expect_st("R1 R3 window end still ground", 1'b0, 2'd0);
    wait_tick();
    expect_st("R3 hold start mid-scale", 1'b0, 2'd1);
    repeat (DAC_HOLD - 1) wait_tick();
    expect_st("R5 dac still mid", 1'b0, 2'd1);
    wait_tick();
    expect_st("R5 dac live, R4 adc still zero", 1'b0, 2'd2);
    repeat (ADC_HOLD - DAC_HOLD - 1) wait_tick();
    expect_st("R4 adc zero before last tick", 1'b0, 2'd2);
    wait_tick();
    expect_st("R4 adc live", 1'b1, 2'd2);

    // sync loss
    wait_tick();
    sync_lost = 1'b1;
    expect_st("R9 no mute before tick", 1'b1, 2'd2);
    wait_tick();
    expect_st("R6 muted at tick", 1'b0, 2'd1);
    repeat (2) wait_tick();
    sync_lost = 1'b0;
    repeat (SYNC_HOLD - 1) wait_tick();
    expect_st("R7 still muted", 1'b0, 2'd1);
    wait_tick();
    expect_st("R7 resumed", 1'b1, 2'd2);

    // sync restart mid-wait
    sync_lost = 1'b1;
    wait_tick();
    sync_lost = 1'b0;
    repeat (2) wait_tick();
    sync_lost = 1'b1;
    edges(1);
    sync_lost = 1'b0;
    repeat (SYNC_HOLD - 1) wait_tick();
    expect_st("R7 restart keeps mute", 1'b0, 2'd1);
    wait_tick();
    expect_st("R7 resumed after restart", 1'b1, 2'd2);

    // ADC power-down only
    adc_pd_n = 1'b0;
    edges(1);
    expect_st("R2 adc pd, dac untouched", 1'b0, 2'd2);
    edges(3);
    adc_pd_n = 1'b1;
    edges(RST_CLKS);
    expect_st("R3 adc window end", 1'b0, 2'd2);
    wait_tick();
    repeat (ADC_HOLD - 1) wait_tick();
    expect_st("R4 adc hold before last tick", 1'b0, 2'd2);
    wait_tick();
    expect_st("R4 adc live again", 1'b1, 2'd2);

    // DAC one-cycle power-down pulse
    dac_pd_n = 1'b0;
    edges(1);
    dac_pd_n = 1'b1;
    expect_st("R2 dac ground, adc untouched", 1'b1, 2'd0);
    edges(RST_CLKS);
    expect_st("R3 dac window end ground", 1'b1, 2'd0);
    wait_tick();
    expect_st("R3 dac mid", 1'b1, 2'd1);
    repeat (2) wait_tick();
    dac_pd_n = 1'b0;
    edges(1);
    dac_pd_n = 1'b1;
    expect_st("R8 pd in hold back to ground", 1'b1, 2'd0);
    edges(RST_CLKS);
    expect_st("R8 restarted window ground", 1'b1, 2'd0);
    wait_tick();
    repeat (DAC_HOLD - 1) wait_tick();
    expect_st("R8 full hold again mid", 1'b1, 2'd1);
    wait_tick();
    expect_st("R5 dac live after restart", 1'b1, 2'd2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete (actual hung / expected done)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule